// File: doc/BRIEF.md
# Overspeed Warning Tone Generator

This block drives a speaker with a single logic-level square wave that warns the driver of excessive road speed. Speed arrives as an unsigned binary count of tenths of a mile per hour. The block sorts it into one of four bands: silent, low, mid or high. Each sounding band has its own pitch, and every pitch is divided from the system clock. The high band has the highest pitch and wins whenever more than one threshold is met. The whole tone is chopped on and off at 10 Hz so that the warning pulses rather than drones.

A single half-period counter produces the tone, and its reload value depends on the active band. The active band is replaced only when a full tone period ends, so a speed change never cuts a high or low half short. The chopping gate restarts with a full open window whenever the warning starts from silence. A separate `stopped` input marks a stalled engine. It forces the output low at once and silences the band. The clock rate, pitches, chop rate and speed thresholds are all parameters, and the dividers are computed from them during elaboration.

Top module: `overspeed_tone`

## Requirements
- R1: While `rst_n` is low, `tone_out` is 0.
- R2: With a speed code below 600 (60.0 mph), `tone_out` stays 0.
- R3: With a speed code from 600 to 699, the tone's high and low halves each last CLK_HZ/1000 clock cycles (500 Hz).
- R4: With a speed code from 700 to 799, each half lasts CLK_HZ/4000 cycles (2 kHz).
- R5: With a speed code of 800 or more, up to the full code 2047, each half lasts CLK_HZ/10000 cycles (5 kHz). The high band takes priority over the lower thresholds.
- R6: When the warning starts from silence, the tone is passed for CLK_HZ/20 cycles and then blocked for CLK_HZ/20 cycles, repeating at 10 Hz. The first tone cycle falls at the start of an open window.
- R7: A change of band takes effect only after the current tone period has finished. The high half in progress and the low half that follows it both keep their full length, and no shortened pulse appears.
- R8: While `stopped` is 1, `tone_out` is 0 in the same cycle. The tone restarts with a fresh open window after `stopped` returns to 0.
- R9: Within an open window, every high half and every low half of the tone have equal length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_tenths | input | SPD_W (11) | Road speed in tenths of mph, unsigned |
| stopped | input | 1 | Engine-stopped flag; silences the output |
| tone_out | output | 1 | Gated square-wave speaker drive |

## Verification
The hardest condition to reach is a band change that lands partway through a tone half-period. That is the only case in which a runt pulse could appear. The stimulus starts a tone from reset, waits a known number of cycles into the first high half, and then moves the speed into another band. It then measures the width of the unfinished pulse, the low gap that follows, and the first pulse of the new pitch. All three must match the period lengths. A second case drops the speed below the lowest threshold during a high-band pulse and checks that this pulse still completes. A third case raises the stopped flag during a pulse, then clears it and checks that a complete fresh gate window follows.

// File: rtl/overspeed_tone_pkg.sv
package overspeed_tone_pkg;

    typedef enum logic [1:0] {
        BAND_OFF  = 2'd0,
        BAND_LOW  = 2'd1,
        BAND_MID  = 2'd2,
        BAND_HIGH = 2'd3
    } band_e;

endpackage

// File: rtl/ovs_band_select.sv
module ovs_band_select
    import overspeed_tone_pkg::*;
#(
    parameter int SPD_W    = 11,
    parameter int LOW_THR  = 600,
    parameter int MID_THR  = 700,
    parameter int HIGH_THR = 800
) (
    input  logic [SPD_W-1:0] speed,
    input  logic             halt,
    output band_e            band_req
);

    // Highest band is tested first so it takes priority.
    always_comb begin
        if (halt)
            band_req = BAND_OFF;
        else if (speed >= SPD_W'(HIGH_THR))
            band_req = BAND_HIGH;
        else if (speed >= SPD_W'(MID_THR))
            band_req = BAND_MID;
        else if (speed >= SPD_W'(LOW_THR))
            band_req = BAND_LOW;
        else
            band_req = BAND_OFF;
    end

endmodule

// File: rtl/ovs_tone_divider.sv
module ovs_tone_divider
    import overspeed_tone_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int HALF_LOW  = 100,
    parameter int HALF_MID  = 25,
    parameter int HALF_HIGH = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  band_e            band_req,
    output band_e            band_act,
    output logic             phase,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        band_e            band;
        logic             ph;
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    function automatic logic [CNT_W-1:0] reload(band_e b);
        case (b)
            BAND_LOW:  return CNT_W'(HALF_LOW - 1);
            BAND_MID:  return CNT_W'(HALF_MID - 1);
            BAND_HIGH: return CNT_W'(HALF_HIGH - 1);
            default:   return '0;
        endcase
    endfunction

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else if (st_q.ph) begin
            // end of high half: low half of the same band follows
            st_d.ph  = 1'b0;
            st_d.cnt = reload(st_q.band);
        end else begin
            // period boundary: the only place a new band is adopted
            st_d.band = band_req;
            st_d.ph   = (band_req != BAND_OFF);
            st_d.cnt  = reload(band_req);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.band <= BAND_OFF;
            st_q.ph   <= 1'b0;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign band_act = st_q.band;
    assign phase    = st_q.ph;
    assign count    = st_q.cnt;

endmodule

// File: rtl/ovs_gate_timer.sv
module ovs_gate_timer #(
    parameter int GATE_HALF = 5000,
    parameter int G_W       = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic open
);

    typedef struct packed {
        logic           open;
        logic [G_W-1:0] cnt;
    } gate_state_t;

    gate_state_t gs_d, gs_q;

    always_comb begin
        gs_d = gs_q;
        if (!run) begin
            gs_d.open = 1'b1;
            gs_d.cnt  = '0;
        end else if (gs_q.cnt == G_W'(GATE_HALF - 1)) begin
            gs_d.open = ~gs_q.open;
            gs_d.cnt  = '0;
        end else begin
            gs_d.cnt = gs_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gs_q.open <= 1'b1;
            gs_q.cnt  <= '0;
        end else begin
            gs_q <= gs_d;
        end
    end

    assign open = gs_q.open;

endmodule

// File: rtl/overspeed_tone.sv
module overspeed_tone
    import overspeed_tone_pkg::*;
#(
    parameter int CLK_HZ       = 100_000_000,
    parameter int SPD_W        = 11,
    parameter int LOW_THR      = 600,
    parameter int MID_THR      = 700,
    parameter int HIGH_THR     = 800,
    parameter int TONE_LOW_HZ  = 500,
    parameter int TONE_MID_HZ  = 2000,
    parameter int TONE_HIGH_HZ = 5000,
    parameter int CHOP_HZ      = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SPD_W-1:0] speed_tenths,
    input  logic             stopped,
    output logic             tone_out
);

    localparam int HALF_LOW  = CLK_HZ / (2 * TONE_LOW_HZ);
    localparam int HALF_MID  = CLK_HZ / (2 * TONE_MID_HZ);
    localparam int HALF_HIGH = CLK_HZ / (2 * TONE_HIGH_HZ);
    localparam int GATE_HALF = CLK_HZ / (2 * CHOP_HZ);
    localparam int CNT_W     = $clog2(HALF_LOW + 1);
    localparam int G_W       = $clog2(GATE_HALF + 1);

    band_e            band_req;
    band_e            act_band;
    logic             tone_ph;
    logic [CNT_W-1:0] tone_cnt;
    logic             gate_open;

    ovs_band_select #(
        .SPD_W   (SPD_W),
        .LOW_THR (LOW_THR),
        .MID_THR (MID_THR),
        .HIGH_THR(HIGH_THR)
    ) u_sel (
        .speed   (speed_tenths),
        .halt    (stopped),
        .band_req(band_req)
    );

    ovs_tone_divider #(
        .CNT_W    (CNT_W),
        .HALF_LOW (HALF_LOW),
        .HALF_MID (HALF_MID),
        .HALF_HIGH(HALF_HIGH)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .band_req(band_req),
        .band_act(act_band),
        .phase   (tone_ph),
        .count   (tone_cnt)
    );

    ovs_gate_timer #(
        .GATE_HALF(GATE_HALF),
        .G_W      (G_W)
    ) u_gate (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (act_band != BAND_OFF),
        .open (gate_open)
    );

    assign tone_out = tone_ph & gate_open & ~stopped;

endmodule

// File: rtl/ovs_tone_checker.sv
module ovs_tone_checker #(
    parameter int SPD_W     = 11,
    parameter int LOW_THR   = 600,
    parameter int HIGH_THR  = 800,
    parameter int CNT_W     = 8,
    parameter int HALF_HIGH = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SPD_W-1:0] speed_tenths,
    input logic             stopped,
    input logic             tone_out,
    input logic [1:0]       act_band,
    input logic             tone_ph,
    input logic [CNT_W-1:0] tone_cnt
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> !tone_out);  // R1

    AST_STOP_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> !tone_out);  // R8

    AST_START_NEEDS_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tone_ph) |-> ($past(speed_tenths) >= SPD_W'(LOW_THR)) && !$past(stopped));  // R2

    AST_HIGH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tone_ph) && $past(speed_tenths) >= SPD_W'(HIGH_THR))
            |-> tone_cnt == CNT_W'(HALF_HIGH - 1));  // R5

    AST_BAND_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !(tone_ph == 1'b0 && tone_cnt == '0) |=> $stable(act_band));  // R7

    AST_EDGE_ON_COUNT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tone_ph) |-> $past(tone_cnt) == '0);  // R9

endmodule

bind overspeed_tone ovs_tone_checker #(
    .SPD_W    (SPD_W),
    .LOW_THR  (LOW_THR),
    .HIGH_THR (HIGH_THR),
    .CNT_W    (CNT_W),
    .HALF_HIGH(HALF_HIGH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .speed_tenths(speed_tenths),
    .stopped     (stopped),
    .tone_out    (tone_out),
    .act_band    (act_band),
    .tone_ph     (tone_ph),
    .tone_cnt    (tone_cnt)
);

// File: tb/overspeed_tone_test.sv
module overspeed_tone_test;

    localparam int CLK_HZ = 100_000;   // scaled so dividers stay short
    localparam int SPD_W  = 11;
    localparam int GH     = CLK_HZ / 20;
    localparam int H_LOW  = CLK_HZ / 1000;
    localparam int H_MID  = CLK_HZ / 4000;
    localparam int H_HIGH = CLK_HZ / 10000;
    localparam int WATCHDOG_CYCLES = 150_000;

    localparam int NV = 8;
    localparam logic [SPD_W-1:0] V_SPD [NV] = '{
        11'd0, 11'd599, 11'd600, 11'd699, 11'd700, 11'd799, 11'd800, 11'd2047 };
    localparam int V_HALF [NV] = '{
        0, 0, H_LOW, H_LOW, H_MID, H_MID, H_HIGH, H_HIGH };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [SPD_W-1:0] speed_tenths = '0;
    logic             stopped = 1'b0;
    logic             tone_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    overspeed_tone #(.CLK_HZ(CLK_HZ), .SPD_W(SPD_W)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .speed_tenths(speed_tenths),
        .stopped     (stopped),
        .tone_out    (tone_out)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string tag_for(input int half);
        if (half == H_LOW)  return "R3";
        if (half == H_MID)  return "R4";
        if (half == H_HIGH) return "R5";
        return "R2";
    endfunction

    // Reset with inputs applied; release at a falling edge so the next
    // rising edge is the first working edge.
    task automatic do_reset(input logic [SPD_W-1:0] spd, input logic stp);
        @(negedge clk);
        rst_n = 1'b0;
        speed_tenths = spd;
        stopped = stp;
        repeat (3) @(negedge clk);
        check("R1", "tone during reset", int'(tone_out), 0);
        rst_n = 1'b1;
    endtask

    // Sample n falling edges; count completed pulses, total high samples,
    // and halves whose length differs from 'half'.
    task automatic sample_window(input int n, input int half,
                                 output int pulses, output int highs, output int bad);
        int hi_run = 0;
        int lo_run = 0;
        logic prev = 1'b0;
        pulses = 0; highs = 0; bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tone_out) begin
                highs++;
                if (!prev && pulses > 0 && lo_run != half) bad++;
                hi_run++;
                lo_run = 0;
            end else begin
                if (prev) begin
                    pulses++;
                    if (hi_run != half) bad++;
                    hi_run = 0;
                end
                lo_run++;
            end
            prev = tone_out;
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG_CYCLES);
            summary();
            $finish;
        end
    end

    initial begin : main
        int p, h, b;
        // ---- table walk: each band, its edges, and the gate ----
        for (int v = 0; v < NV; v++) begin
            do_reset(V_SPD[v], 1'b0);
            sample_window(GH, V_HALF[v], p, h, b);
            check(tag_for(V_HALF[v]), $sformatf("pulses in open window, speed %0d", V_SPD[v]),
                  p, (V_HALF[v] == 0) ? 0 : GH / (2 * V_HALF[v]));
            check("R9", $sformatf("uneven halves, speed %0d", V_SPD[v]), b, 0);
            sample_window(GH, V_HALF[v], p, h, b);
            check("R6", $sformatf("highs in blocked window, speed %0d", V_SPD[v]), h, 0);
        end

        // ---- R7: low band to high band mid-pulse ----
        begin
            int w[3];
            int gap;
            int cnt;
            int hi_run;
            int lo_run;
            logic prev;
            do_reset(11'd650, 1'b0);
            cnt = 0; hi_run = 0; lo_run = 0; gap = -1; prev = 1'b0;
            w[0] = -1; w[1] = -1; w[2] = -1;
            for (int i = 1; i <= 600; i++) begin
                @(negedge clk);
                if (tone_out) begin
                    if (!prev && cnt == 1) gap = lo_run;
                    hi_run++;
                    lo_run = 0;
                end else begin
                    if (prev) begin
                        if (cnt < 3) w[cnt] = hi_run;
                        cnt++;
                        hi_run = 0;
                    end
                    lo_run++;
                end
                prev = tone_out;
                if (i == 50) speed_tenths = 11'd850;
            end
            check("R7", "pulse in progress at band change", w[0], H_LOW);
            check("R7", "low half after band change", gap, H_LOW);
            check("R7", "first pulse of new band", w[1], H_HIGH);
            check("R7", "second pulse of new band", w[2], H_HIGH);
        end

        // ---- R7: high band to silence mid-pulse ----
        do_reset(11'd850, 1'b0);
        repeat (5) @(negedge clk);
        speed_tenths = 11'd500;
        sample_window(300, H_HIGH, p, h, b);
        check("R7", "pulses after drop to silence", p, 1);
        check("R7", "remaining high samples of last pulse", h, H_HIGH - 5);

        // ---- R8: stopped flag ----
        do_reset(11'd900, 1'b0);
        repeat (3) @(negedge clk);
        check("R8", "tone before stop", int'(tone_out), 1);
        stopped = 1'b1;
        #1;
        check("R8", "tone in cycle stop rises", int'(tone_out), 0);
        sample_window(100, H_HIGH, p, h, b);
        check("R8", "highs while stopped", h, 0);
        stopped = 1'b0;
        sample_window(GH, H_HIGH, p, h, b);
        check("R8", "pulses in fresh window after stop", p, GH / (2 * H_HIGH));
        check("R6", "halves after restart", b, 0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule